// File: doc/BRIEF.md
# Four-Stage Pipelined Register-ALU Core With Jumps

This block is a compact in-order processor core with two instruction classes: a three-register ALU operation and an unconditional jump to an absolute address carried in the instruction. Every instruction moves through four stages in sequence: fetch, decode with register read, execute, and register write-back. A new instruction enters fetch every cycle. With no conflicts, one instruction retires per cycle and four are in flight at once.

The core has no operand forwarding. Decode compares the source registers of the instruction it holds with the destinations of the two older ALU instructions still in execute and write-back. On a match, decode discards its own instruction and the one being fetched. Fetch then restarts at the program counter of the discarded decode instruction. A jump redirects fetch when it reaches execute and discards the two instructions behind it.

The core drives an instruction memory port that returns a word within the same cycle. The register file is inside the core, and every register write is visible on a write-back port.

Top module: `pipe4_core`

## Requirements
- R1: With default parameters the 20-bit instruction word holds the opcode in bits [19:17], the destination register in [16:14], the first source in [13:11], the second source in [10:8] and the jump target in [7:0].
- R2: The ALU opcodes are 0 add, 1 subtract (src1 minus src2), 2 and, 3 or, 4 xor, 5 nor and 6 xnor. Results wrap modulo 2^DATA_W and are written to the destination register. Opcode 7 is the jump, and it writes no register.
- R3: While reset is asserted, the fetch address is 0, no write-back is reported and every register reads as zero. After reset is released, the instruction at address 0 is fetched in cycle 0 and writes back in cycle 3.
- R4: Without jumps or conflicts, the fetch address rises by one each cycle and independent instructions write back in consecutive cycles.
- R5: If a decoded ALU instruction reads a register that the ALU instruction one or two ahead of it will write, it and the instruction behind it are discarded. Fetch resumes at its address, so it writes back two cycles later than it would have, with the updated operand.
- R6: When a jump is in execute, the next fetch address is its target. The target instruction reaches decode three cycles after the jump did.
- R7: The two instructions that follow a jump in memory never write the register file.
- R8: Register 0 is an ordinary register that can be written and read back.
- R9: The fetch address wraps from 2^PC_W-1 to 0.
- R10: An instruction that reads the destination of the instruction three or more ahead of it is not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PC_W | Fetch address |
| imem_data | input | 3+3*RA_W+PC_W | Instruction word for imem_addr, same cycle |
| wb_valid | output | 1 | A register write happens at the end of this cycle |
| wb_reg | output | RA_W | Destination of the write |
| wb_data | output | DATA_W | Value written |

## Verification
The hardest situation to reach from the ports is a conflict at distance two, where the producer is already in write-back while its consumer sits in decode. Another hard case is a squash and refetch that lands right behind a jump or across the address wrap. The stimulus places consumers at distances one, two and three from their producers. It chains jumps back to back, starts a run at a jump to the last addresses so the program counter wraps, and adds a pseudo-random program. An independent timing and value model predicts the exact write-back cycle of every instruction, so both a missing stall and a spurious stall show up as timing mismatches.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_NOR  = 3'd5,
      OP_XNOR = 3'd6,
      OP_JMP  = 3'd7
   } opcode_e;
endpackage

// File: rtl/pipe4_alu.sv
module pipe4_alu
   import pipe4_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOR:  y = ~(a | b);
         OP_XNOR: y = ~(a ^ b);
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
   parameter int DATA_W   = 16,
   parameter int RA_W     = 3,
   parameter bit CLEAR_RF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RA_W-1:0]   wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [RA_W-1:0]   ra1,
   input  logic [RA_W-1:0]   ra2,
   output logic [DATA_W-1:0] rd1,
   output logic [DATA_W-1:0] rd2
);
   localparam int NREG = 1 << RA_W;

   logic [NREG-1:0][DATA_W-1:0] regs;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = we && (wa == RA_W'(g));
      if (CLEAR_RF) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wd;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wd;
         end
      end
      assign regs[g] = q;
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
endmodule

// File: rtl/pipe4_hazard.sv
module pipe4_hazard #(
   parameter int RA_W  = 3,
   parameter int N_OLD = 2
) (
   input  logic                       chk_en,
   input  logic [RA_W-1:0]            src_a,
   input  logic [RA_W-1:0]            src_b,
   input  logic [N_OLD-1:0]           old_v,
   input  logic [N_OLD-1:0][RA_W-1:0] old_rd,
   output logic                       hit
);
   logic [N_OLD-1:0] match;

   for (genvar g = 0; g < N_OLD; g++) begin : g_cmp
      assign match[g] = old_v[g] && ((old_rd[g] == src_a) || (old_rd[g] == src_b));
   end

   assign hit = chk_en && (|match);
endmodule

// File: rtl/pipe4_pc.sv
module pipe4_pc #(
   parameter int PC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            jmp_en,
   input  logic [PC_W-1:0] jmp_tgt,
   input  logic            retry_en,
   input  logic [PC_W-1:0] retry_pc,
   output logic [PC_W-1:0] pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc <= '0;
      else if (jmp_en)   pc <= jmp_tgt;
      else if (retry_en) pc <= retry_pc;
      else               pc <= pc + PC_W'(1);
   end
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
   import pipe4_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RA_W   = 3,
   parameter int PC_W   = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   output logic [PC_W-1:0]                   imem_addr,
   input  logic [pipe4_pkg::OP_W+3*RA_W+PC_W-1:0] imem_data,
   output logic                              wb_valid,
   output logic [RA_W-1:0]                   wb_reg,
   output logic [DATA_W-1:0]                 wb_data
);
   localparam int IW      = OP_W + 3*RA_W + PC_W;
   localparam int RD_LSB  = 2*RA_W + PC_W;
   localparam int RS1_LSB = RA_W + PC_W;
   localparam int RS2_LSB = PC_W;
   localparam int N_OLD   = 2;

   initial begin : param_chk
      if (DATA_W < 1 || RA_W < 1 || PC_W < 1)
         $fatal(1, "pipe4_core: widths must be positive");
   end

   // fetch
   logic [PC_W-1:0] pc_q;

   // decode stage
   logic            dv_q;
   logic [IW-1:0]   d_inst_q;
   logic [PC_W-1:0] d_pc_q;
   opcode_e         d_op;
   logic [RA_W-1:0] d_rd, d_rs1, d_rs2;
   logic [PC_W-1:0] d_tgt;
   logic            d_is_jmp;
   logic [DATA_W-1:0] rf_a, rf_b;

   // execute stage
   logic              ev_q;
   logic              e_jmp_q;
   opcode_e           e_op_q;
   logic [RA_W-1:0]   e_rd_q;
   logic [DATA_W-1:0] e_a_q, e_b_q;
   logic [PC_W-1:0]   e_tgt_q;
   logic [DATA_W-1:0] alu_y;

   // write-back stage
   logic              wv_q;
   logic [RA_W-1:0]   w_rd_q;
   logic [DATA_W-1:0] w_data_q;

   // control
   logic                       jmp_go;
   logic                       raw_hit;
   logic                       flush;
   logic [N_OLD-1:0]           old_v;
   logic [N_OLD-1:0][RA_W-1:0] old_rd;

   assign d_op     = opcode_e'(d_inst_q[IW-1 -: OP_W]);
   assign d_rd     = d_inst_q[RD_LSB  +: RA_W];
   assign d_rs1    = d_inst_q[RS1_LSB +: RA_W];
   assign d_rs2    = d_inst_q[RS2_LSB +: RA_W];
   assign d_tgt    = d_inst_q[PC_W-1:0];
   assign d_is_jmp = (d_op == OP_JMP);

   assign jmp_go = ev_q && e_jmp_q;
   assign flush  = jmp_go || raw_hit;
   assign old_v  = {wv_q, ev_q && !e_jmp_q};
   assign old_rd = {w_rd_q, e_rd_q};

   pipe4_pc #(.PC_W(PC_W)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .jmp_en   (jmp_go),
      .jmp_tgt  (e_tgt_q),
      .retry_en (raw_hit),
      .retry_pc (d_pc_q),
      .pc       (pc_q)
   );

   pipe4_hazard #(.RA_W(RA_W), .N_OLD(N_OLD)) u_haz (
      .chk_en (dv_q && !d_is_jmp),
      .src_a  (d_rs1),
      .src_b  (d_rs2),
      .old_v  (old_v),
      .old_rd (old_rd),
      .hit    (raw_hit)
   );

   pipe4_regfile #(.DATA_W(DATA_W), .RA_W(RA_W), .CLEAR_RF(1'b1)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wv_q),
      .wa    (w_rd_q),
      .wd    (w_data_q),
      .ra1   (d_rs1),
      .ra2   (d_rs2),
      .rd1   (rf_a),
      .rd2   (rf_b)
   );

   pipe4_alu #(.DATA_W(DATA_W)) u_alu (
      .op (e_op_q),
      .a  (e_a_q),
      .b  (e_b_q),
      .y  (alu_y)
   );

   // fetch -> decode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q     <= 1'b0;
         d_inst_q <= '0;
         d_pc_q   <= '0;
      end else begin
         dv_q     <= !flush;
         d_inst_q <= imem_data;
         d_pc_q   <= pc_q;
      end
   end

   // decode -> execute
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q    <= 1'b0;
         e_jmp_q <= 1'b0;
         e_op_q  <= OP_ADD;
         e_rd_q  <= '0;
         e_a_q   <= '0;
         e_b_q   <= '0;
         e_tgt_q <= '0;
      end else begin
         ev_q    <= dv_q && !flush;
         e_jmp_q <= d_is_jmp;
         e_op_q  <= d_op;
         e_rd_q  <= d_rd;
         e_a_q   <= rf_a;
         e_b_q   <= rf_b;
         e_tgt_q <= d_tgt;
      end
   end

   // execute -> write-back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wv_q     <= 1'b0;
         w_rd_q   <= '0;
         w_data_q <= '0;
      end else begin
         wv_q     <= ev_q && !e_jmp_q;
         w_rd_q   <= e_rd_q;
         w_data_q <= alu_y;
      end
   end

   assign imem_addr = pc_q;
   assign wb_valid  = wv_q;
   assign wb_reg    = w_rd_q;
   assign wb_data   = w_data_q;
endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk #(
   parameter int PC_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] pc,
   input logic            wb_valid,
   input logic            ex_valid,
   input logic            jmp_go,
   input logic [PC_W-1:0] jmp_tgt,
   input logic            raw_hit,
   input logic [PC_W-1:0] retry_pc
);
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!jmp_go && !raw_hit) |=> (pc == $past(pc) + PC_W'(1))); // R4

   AST_RAW_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_hit && !jmp_go) |=> (pc == $past(retry_pc))); // R5

   AST_JMP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_go |=> (pc == $past(jmp_tgt))); // R6

   AST_JMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_go |=> !wb_valid); // R2

   AST_JMP_KILL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_go |=> !ex_valid); // R7

   AST_JMP_KILL_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_go |=> ##1 !wb_valid ##1 !wb_valid); // R7
endmodule

bind pipe4_core pipe4_core_chk #(.PC_W(PC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pc       (imem_addr),
   .wb_valid (wb_valid),
   .ex_valid (ev_q),
   .jmp_go   (jmp_go),
   .jmp_tgt  (e_tgt_q),
   .raw_hit  (raw_hit),
   .retry_pc (d_pc_q)
);

// File: tb/pipe4_core_tb.sv
module pipe4_core_tb;
   localparam int DW  = 16;
   localparam int AW  = 3;
   localparam int PW  = 8;
   localparam int IW  = 3 + 3*AW + PW;
   localparam int WIN = 60;

   typedef struct {
      int          rd;
      logic [15:0] val;
      int          cyc;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] imem_addr;
   logic [IW-1:0] imem_data;
   logic          wb_valid;
   logic [AW-1:0] wb_reg;
   logic [DW-1:0] wb_data;

   logic [IW-1:0] prog [256];
   exp_t q[$];
   int   cyc = 0;
   bit   live = 1'b0;
   int   n_chk = 0, n_err = 0;
   int   mon_chk = 0, mon_err = 0;

   always #4 clk = ~clk;

   assign imem_data = prog[imem_addr];

   pipe4_core #(.DATA_W(DW), .RA_W(AW), .PC_W(PW)) u_dut (
      .clk (clk), .rst_n (rst_n), .imem_addr (imem_addr), .imem_data (imem_data),
      .wb_valid (wb_valid), .wb_reg (wb_reg), .wb_data (wb_data)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // R1 field layout
   function automatic logic [IW-1:0] enc(int op, int rd, int a, int b, int t);
      return {3'(op), 3'(rd), 3'(a), 3'(b), 8'(t)};
   endfunction

   // R2 operation table
   function automatic logic [15:0] alu_ref(int op, logic [15:0] a, logic [15:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return a & b;
         3: return a | b;
         4: return a ^ b;
         5: return ~(a | b);
         default: return ~(a ^ b);
      endcase
   endfunction

   // scoreboard driver: sequential model with stage timing (R3 R4 R5 R6 R9 R10)
   task automatic build_expect(string tag);
      logic [15:0] rf [8];
      int pc = 0, d = 1;
      int o_rd [2] = '{-1, -1};
      int o_d  [2] = '{-100, -100};
      for (int i = 0; i < 8; i++) rf[i] = '0;
      while (d < WIN) begin
         logic [IW-1:0] w = prog[pc];
         int op  = int'(w[19:17]);
         int rd  = int'(w[16:14]);
         int ra  = int'(w[13:11]);
         int rb  = int'(w[10:8]);
         int tgt = int'(w[7:0]);
         if (op == 7) begin
            pc = tgt;
            d  = d + 3;
         end else begin
            bit stall = 1'b0;
            for (int k = 0; k < 2; k++)
               if (o_d[k] >= d - 2 && (ra == o_rd[k] || rb == o_rd[k])) stall = 1'b1;
            if (stall) d = d + 2;
            if (d + 2 >= WIN) break;
            begin
               exp_t e;
               e.rd = rd; e.val = alu_ref(op, rf[ra], rf[rb]); e.cyc = d + 2; e.tag = tag;
               q.push_back(e);
               rf[rd] = e.val;
            end
            o_rd[1] = o_rd[0]; o_d[1] = o_d[0];
            o_rd[0] = rd;      o_d[0] = d;
            pc = (pc + 1) % 256;
            d  = d + 1;
         end
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && live && wb_valid && cyc < WIN) begin
         mon_chk++;
         if (q.size() == 0) begin
            mon_err++;
            $display("FAIL R7 unexpected write r%0d=%h at cycle %0d, expected none", wb_reg, wb_data, cyc);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (int'(wb_reg) != e.rd || wb_data !== e.val || cyc != e.cyc) begin
               mon_err++;
               $display("FAIL %s write actual r%0d=%h@%0d expected r%0d=%h@%0d",
                        e.tag, wb_reg, wb_data, cyc, e.rd, e.val, e.cyc);
            end
         end
      end
   end

   task automatic check(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic run_prog(string tag);
      rst_n = 1'b0;
      live  = 1'b0;
      repeat (2) @(negedge clk);
      // R3 reset state
      check(imem_addr == '0, "R3 reset fetch address", int'(imem_addr), 0);
      check(wb_valid == 1'b0, "R3 reset write-back idle", int'(wb_valid), 0);
      q.delete();
      build_expect(tag);
      @(negedge clk);
      rst_n = 1'b1;
      live  = 1'b1;
      #1;
      check(imem_addr == '0, "R3 first fetch at address 0", int'(imem_addr), 0);
      repeat (WIN) @(negedge clk);
      check(q.size() == 0, {tag, " missing writes"}, q.size(), 0);
      live  = 1'b0;
      rst_n = 1'b0;
   endtask

   initial begin
      // P1: mostly independent, distance-3 reuse (R1 R2 R4 R10)
      for (int i = 0; i < 256; i++) prog[i] = enc(7, 0, 0, 0, i);
      prog[0] = enc(5, 1, 0, 0, 0);
      prog[1] = enc(6, 2, 0, 0, 0);
      prog[2] = enc(3, 3, 4, 5, 0);
      prog[3] = enc(1, 4, 0, 1, 0);
      prog[4] = enc(4, 5, 2, 6, 0);
      prog[5] = enc(0, 6, 1, 2, 0);
      prog[6] = enc(2, 7, 1, 4, 0);
      prog[7] = enc(1, 3, 6, 7, 0);
      prog[8] = enc(7, 0, 0, 0, 8);
      run_prog("R1/R2/R4/R10");

      // P2: conflicts at distance 1 and 2, register 0 as data (R5 R8)
      for (int i = 0; i < 256; i++) prog[i] = enc(7, 0, 0, 0, i);
      prog[0] = enc(5, 1, 0, 0, 0);
      prog[1] = enc(0, 2, 1, 1, 0);
      prog[2] = enc(1, 0, 2, 1, 0);
      prog[3] = enc(5, 3, 5, 6, 0);
      prog[4] = enc(2, 4, 0, 2, 0);
      prog[5] = enc(0, 0, 0, 4, 0);
      prog[6] = enc(4, 5, 0, 3, 0);
      run_prog("R5/R8");

      // P3: jumps, back-to-back jumps, shadow slots loaded with writes (R6 R7)
      for (int i = 0; i < 256; i++) prog[i] = enc(5, 7, 0, 0, 0);
      prog[0]  = enc(5, 1, 0, 0, 0);
      prog[1]  = enc(7, 0, 0, 0, 5);
      prog[2]  = enc(0, 2, 1, 1, 0);
      prog[3]  = enc(4, 3, 1, 0, 0);
      prog[5]  = enc(1, 5, 0, 1, 0);
      prog[6]  = enc(7, 0, 0, 0, 9);
      prog[9]  = enc(7, 0, 0, 0, 12);
      prog[12] = enc(0, 6, 5, 5, 0);
      prog[13] = enc(7, 0, 0, 0, 13);
      run_prog("R6/R7");

      // P4: address wrap with a conflict right after the wrap target (R9 R5)
      for (int i = 0; i < 256; i++) prog[i] = enc(7, 0, 0, 0, 0);
      prog[0]   = enc(7, 0, 0, 0, 253);
      prog[253] = enc(5, 1, 0, 0, 0);
      prog[254] = enc(0, 2, 1, 1, 0);
      prog[255] = enc(1, 3, 2, 1, 0);
      run_prog("R9");

      // P5: pseudo-random ALU stream (R2 R5 R10)
      begin
         int unsigned s = 32'h1bad_c0de;
         for (int i = 0; i < 256; i++) prog[i] = enc(7, 0, 0, 0, i);
         for (int i = 0; i < 40; i++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            prog[i] = enc(int'(s % 7), int'((s >> 4) & 7), int'((s >> 8) & 7),
                          int'((s >> 12) & 7), 0);
         end
         run_prog("R2/R5/R10 random");
      end

      $display("CHECKS %0d ERRORS %0d", n_chk + mon_chk, n_err + mon_err);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      $display("FAIL watchdog expired, actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk + mon_chk + 1, n_err + mon_err + 1);
      $finish;
   end
endmodule